// File: doc/BRIEF.md
# SDRAM Bank Command Timing Controller

This block sits between a simple request port and a four-bank synchronous DRAM. Each request names a bank, a row, a column, a byte mask, a direction and an auto-precharge flag. The block keeps a record of the open row in every bank. It closes and opens rows as needed, then issues the single-beat column command. Every command is spaced by the minimum clock counts the memory demands.

Each bank has its own set of down-counters: activate to column, activate to precharge, activate to activate, precharge to activate, and write recovery. A few global counters cover activates to different banks, write to next column, and read-to-write bus turnaround. The block captures read data exactly CAS-latency clocks after the read command. The latency is 1, 2 or 3 and comes from an input. Byte masks reach the memory's mask pins with zero latency for writes and two clocks of latency for reads.

Top module: `sdram_cmd_sched`

## Requirements
- R1: Commands appear on {cs_n, ras_n, cas_n, we_n} as ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, NOP=0111 (no other code is driven), and sd_ba carries the request bank as 00/01/10/11 for banks 0 to 3.
- R2: A request to the row already open in its bank issues only the column command, with no ACTIVE or PRECHARGE.
- R3: A request to an open bank with a different row issues PRECHARGE of that bank only (sd_addr[10]=0), then ACTIVE, then the column command; a closed bank gets ACTIVE first.
- R4: A column command is issued no earlier than T_RCD (3) clocks after the ACTIVE of its bank.
- R5: ACTIVE to a bank comes no earlier than T_RP (3) clocks after its PRECHARGE.
- R6: PRECHARGE comes at least T_RAS (7) clocks after the bank's ACTIVE, and two ACTIVEs to one bank are at least T_RC (10) clocks apart.
- R7: ACTIVE commands to any banks are at least T_RRD (2) clocks apart.
- R8: PRECHARGE comes at least T_RDL (2) clocks after a WRITE to that bank, and a READ comes at least T_CDL (1) clock after any WRITE.
- R9: With the auto-precharge flag, the column command carries sd_addr[10]=1. The bank then counts as closed. Its next ACTIVE waits T_RP after the burst end, which is the READ cycle for a read and T_RDL clocks after the WRITE for a write.
- R10: Read data on the pins in cycle n+CL, for a READ in cycle n, is presented on rd_data with rd_valid high in cycle n+CL+1; rd_valid pulses once per read, in request order.
- R11: On a write, sd_dqm equals req_mask in the WRITE cycle (latency 0); a mask bit of 1 leaves that byte of memory unchanged.
- R12: On a read, sd_dqm equals req_mask two clocks before the data cycle, so a mask bit of 1 makes that byte read as zero. For CL=1 this requires a NOP cycle carrying the mask just before the READ.
- R13: A WRITE is not issued before CL+1 clocks after a READ, so the data bus is never driven during a read data cycle.
- R14: During and right after reset the pins show NOP, rd_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cas_lat | input | 2 | Programmed CAS latency, 1 to 3 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 11 | Target row |
| req_col | input | 8 | Target column |
| req_autopre | input | 1 | Close the bank after this access |
| req_mask | input | 4 | Byte mask, 1 = byte blanked |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 11 | Row, or column plus auto-precharge bit 10 |
| sd_dqm | output | 4 | Byte mask pins |
| sd_dq_out | output | 32 | Write data to memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 32 | Read data from memory |

## Verification
The hardest case to reach is a masked read at CAS latency 1. Its mask has to go out one clock before the READ itself. This cycle matters only when the controller is also keeping a row open across requests. The bench reaches it by first writing a row at latency 3, changing the latency to 2 and then 1 while the block is idle, and reading that still-open row with a mask. Its memory model blanks bytes from the mask pins seen two clocks before the data cycle, so a mask placed in the wrong cycle shows up as wrong bytes. The same model checks every spacing rule at each command it decodes. It covers back-to-back activates across banks, write-then-precharge on a row miss, and read-then-write turnaround.

// File: rtl/sdram_sched_pkg.sv
package sdram_sched_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_ACT = 4'b0011,
        CMD_PRE = 4'b0010,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        STEP_IDLE,
        STEP_PRE,
        STEP_ACT,
        STEP_MASK,
        STEP_COL
    } step_e;

    // A gap of d clocks between commands: the counter is loaded with d-1
    // and the next command may be chosen once it reads zero.
    function automatic int gap_load(int d);
        return (d > 1) ? d - 1 : 0;
    endfunction

endpackage

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer
    import sdram_sched_pkg::*;
#(
    parameter int ROW_W = 11,
    parameter int TW    = 5,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RAS = 7,
    parameter int T_RC  = 10,
    parameter int T_RDL = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic             ap_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             act_ok_o,
    output logic             pre_ok_o,
    output logic             col_ok_o
);

    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [TW-1:0]    rcd_c, ras_c, rc_c, rp_c, wrr_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
            rcd_c  <= '0;
            ras_c  <= '0;
            rc_c   <= '0;
            rp_c   <= '0;
            wrr_c  <= '0;
        end else begin
            rcd_c <= (rcd_c != 0) ? rcd_c - 1'b1 : rcd_c;
            ras_c <= (ras_c != 0) ? ras_c - 1'b1 : ras_c;
            rc_c  <= (rc_c  != 0) ? rc_c  - 1'b1 : rc_c;
            rp_c  <= (rp_c  != 0) ? rp_c  - 1'b1 : rp_c;
            wrr_c <= (wrr_c != 0) ? wrr_c - 1'b1 : wrr_c;
            if (act_i) begin
                open_q <= 1'b1;
                row_q  <= row_i;
                rcd_c  <= TW'(gap_load(T_RCD));
                ras_c  <= TW'(gap_load(T_RAS));
                rc_c   <= TW'(gap_load(T_RC));
            end
            if (pre_i) begin
                open_q <= 1'b0;
                rp_c   <= TW'(gap_load(T_RP));
            end
            if (wr_i) begin
                wrr_c <= TW'(gap_load(T_RDL));
                if (ap_i) begin
                    open_q <= 1'b0;
                    rp_c   <= TW'(gap_load(T_RDL + T_RP));
                end
            end
            if (rd_i && ap_i) begin
                open_q <= 1'b0;
                rp_c   <= TW'(gap_load(T_RP));
            end
        end
    end

    assign open_o   = open_q;
    assign row_o    = row_q;
    assign act_ok_o = !open_q && (rp_c == 0) && (rc_c == 0);
    assign pre_ok_o = open_q && (ras_c == 0) && (wrr_c == 0);
    assign col_ok_o = open_q && (rcd_c == 0);

    // R5: the scheduler only activates a bank this timer holds closed
    assert_act_closed_R5: assert property (@(posedge clk) disable iff (rst)
        act_i |-> !open_q && rp_c == 0);

    // R4: column commands only reach an open bank past its row-to-column gap
    assert_col_open_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_i || wr_i) |-> open_q && rcd_c == 0);

    // R6 and R8: precharge respects active time and write recovery
    assert_pre_window_R6: assert property (@(posedge clk) disable iff (rst)
        pre_i |-> ras_c == 0 && wrr_c == 0);

endmodule

// File: rtl/sdram_rd_align.sv
module sdram_rd_align #(
    parameter int DW     = 32,
    parameter int MAX_CL = 3,
    parameter int CLW    = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_fire_i,
    input  logic [CLW-1:0] cas_lat_i,
    input  logic [DW-1:0]  dq_i,
    output logic           rd_valid_o,
    output logic [DW-1:0]  rd_data_o
);

    // pipe_q[k] is high k clocks after a READ sat on the pins
    logic [MAX_CL:1] pipe_q;
    logic            tap;

    always_comb begin
        tap = 1'b0;
        for (int k = 1; k <= MAX_CL; k++) begin
            if (int'(cas_lat_i) == k) tap = pipe_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q     <= '0;
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            pipe_q     <= {pipe_q[MAX_CL-1:1], rd_fire_i};
            rd_valid_o <= tap;
            if (tap) rd_data_o <= dq_i;
        end
    end

    // R10: a read is only launched with a latency the capture pipe supports
    assert_cl_range_R10: assert property (@(posedge clk) disable iff (rst)
        rd_fire_i |-> (int'(cas_lat_i) >= 1 && int'(cas_lat_i) <= MAX_CL));

endmodule

// File: rtl/sdram_cmd_sched.sv
module sdram_cmd_sched
    import sdram_sched_pkg::*;
#(
    parameter int DW     = 32,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 11,
    parameter int COL_W  = 8,
    parameter int AP_BIT = 10,
    parameter int MAX_CL = 3,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 7,
    parameter int T_RC   = 10,
    parameter int T_RRD  = 2,
    parameter int T_RDL  = 2,
    parameter int T_CDL  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cas_lat,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_autopre,
    input  logic [DW/8-1:0]   req_mask,
    input  logic [DW-1:0]     req_wdata,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DW/8-1:0]   sd_dqm,
    output logic [DW-1:0]     sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DW-1:0]     sd_dq_in
);

    localparam int NBANK = 1 << BANK_W;
    localparam int MW    = DW / 8;
    localparam int CLW   = 2;
    localparam int TW    = $clog2(T_RDL + T_RP + T_RC + MAX_CL + 2);

    typedef struct packed {
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              ap;
        logic [MW-1:0]     mask;
        logic [DW-1:0]     data;
    } req_t;

    req_t           cur_q;
    logic           busy_q, premask_q;
    sd_cmd_e        cmd_q;
    logic [MW-1:0]  rd_pend_q;
    logic [TW-1:0]  rrd_c, bus_c, cdl_c;
    step_e          step;
    logic           hit, col_gate;

    logic [NBANK-1:0] act_v, pre_v, rd_v, wr_v;
    logic [NBANK-1:0] open_v, act_ok_v, pre_ok_v, col_ok_v;
    logic [ROW_W-1:0] row_v [NBANK];

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        assign act_v[i] = (step == STEP_ACT) && (cur_q.bank == BANK_W'(i));
        assign pre_v[i] = (step == STEP_PRE) && (cur_q.bank == BANK_W'(i));
        assign rd_v[i]  = (step == STEP_COL) && !cur_q.wr && (cur_q.bank == BANK_W'(i));
        assign wr_v[i]  = (step == STEP_COL) &&  cur_q.wr && (cur_q.bank == BANK_W'(i));
        sdram_bank_timer #(
            .ROW_W(ROW_W), .TW(TW), .T_RCD(T_RCD), .T_RP(T_RP),
            .T_RAS(T_RAS), .T_RC(T_RC), .T_RDL(T_RDL)
        ) u_timer (
            .clk(clk), .rst(rst),
            .act_i(act_v[i]), .pre_i(pre_v[i]), .rd_i(rd_v[i]), .wr_i(wr_v[i]),
            .ap_i(cur_q.ap), .row_i(cur_q.row),
            .open_o(open_v[i]), .row_o(row_v[i]),
            .act_ok_o(act_ok_v[i]), .pre_ok_o(pre_ok_v[i]), .col_ok_o(col_ok_v[i])
        );
    end

    always_comb begin
        step     = STEP_IDLE;
        hit      = open_v[cur_q.bank] && (row_v[cur_q.bank] == cur_q.row);
        col_gate = col_ok_v[cur_q.bank] && (cdl_c == 0) && (!cur_q.wr || bus_c == 0);
        if (busy_q) begin
            if (open_v[cur_q.bank] && !hit) begin
                if (pre_ok_v[cur_q.bank]) step = STEP_PRE;
            end else if (!open_v[cur_q.bank]) begin
                if (act_ok_v[cur_q.bank] && rrd_c == 0) step = STEP_ACT;
            end else if (col_gate) begin
                if (!cur_q.wr && cas_lat == 2'd1 && |cur_q.mask && !premask_q)
                    step = STEP_MASK;
                else
                    step = STEP_COL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= '0;
            busy_q    <= 1'b0;
            premask_q <= 1'b0;
            cmd_q     <= CMD_NOP;
            sd_ba     <= '0;
            sd_addr   <= '0;
            sd_dqm    <= '0;
            sd_dq_out <= '0;
            sd_dq_oe  <= 1'b0;
            rd_pend_q <= '0;
            rrd_c     <= '0;
            bus_c     <= '0;
            cdl_c     <= '0;
        end else begin
            rrd_c     <= (rrd_c != 0) ? rrd_c - 1'b1 : rrd_c;
            bus_c     <= (bus_c != 0) ? bus_c - 1'b1 : bus_c;
            cdl_c     <= (cdl_c != 0) ? cdl_c - 1'b1 : cdl_c;
            cmd_q     <= CMD_NOP;
            sd_dq_oe  <= 1'b0;
            sd_dqm    <= rd_pend_q;
            rd_pend_q <= '0;
            if (req_valid && !busy_q) begin
                busy_q <= 1'b1;
                cur_q  <= '{wr: req_write, bank: req_bank, row: req_row, col: req_col,
                            ap: req_autopre, mask: req_mask, data: req_wdata};
            end
            case (step)
                STEP_PRE: begin
                    cmd_q   <= CMD_PRE;
                    sd_ba   <= cur_q.bank;
                    sd_addr <= '0;
                end
                STEP_ACT: begin
                    cmd_q   <= CMD_ACT;
                    sd_ba   <= cur_q.bank;
                    sd_addr <= cur_q.row;
                    rrd_c   <= TW'(gap_load(T_RRD));
                end
                STEP_MASK: begin
                    sd_dqm    <= cur_q.mask;
                    premask_q <= 1'b1;
                end
                STEP_COL: begin
                    sd_ba               <= cur_q.bank;
                    sd_addr             <= '0;
                    sd_addr[COL_W-1:0]  <= cur_q.col;
                    sd_addr[AP_BIT]     <= cur_q.ap;
                    busy_q              <= 1'b0;
                    premask_q           <= 1'b0;
                    if (cur_q.wr) begin
                        cmd_q     <= CMD_WR;
                        sd_dqm    <= cur_q.mask;
                        sd_dq_out <= cur_q.data;
                        sd_dq_oe  <= 1'b1;
                        cdl_c     <= TW'(gap_load(T_CDL));
                    end else begin
                        cmd_q <= CMD_RD;
                        bus_c <= TW'(cas_lat);
                        if (cas_lat == 2'd2) sd_dqm <= cur_q.mask;
                        if (cas_lat == 2'd3) rd_pend_q <= cur_q.mask;
                    end
                end
                default: ;
            endcase
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign req_ready = !busy_q;

    sdram_rd_align #(.DW(DW), .MAX_CL(MAX_CL), .CLW(CLW)) u_rd (
        .clk(clk), .rst(rst), .rd_fire_i(cmd_q == CMD_RD), .cas_lat_i(cas_lat),
        .dq_i(sd_dq_in), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
    );

    // R14: the first cycle after reset shows no command and no read data
    assert_reset_nop_R14: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmd_q == CMD_NOP && !rd_valid));

    // R7: no two activates on adjacent cycles when the rule spans more than one clock
    assert_rrd_R7: assert property (@(posedge clk) disable iff (rst)
        (T_RRD > 1 && cmd_q == CMD_ACT) |=> cmd_q != CMD_ACT);

    // R13: a write never overlaps a read data cycle
    assert_wr_bus_R13: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_WR) |=> !rd_valid);

endmodule

// File: tb/tb_sdram_cmd_sched.sv
module tb_sdram_cmd_sched;

    localparam int T_RCD = 3, T_RP = 3, T_RAS = 7, T_RC = 10, T_RRD = 2, T_RDL = 2, T_CDL = 1;

    logic        clk = 1'b0, rst = 1'b1;
    logic [1:0]  cas_lat = 2'd3;
    logic        req_valid = 1'b0, req_ready, req_write = 1'b0, req_autopre = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [10:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic [3:0]  req_mask = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0]  sd_ba;
    logic [10:0] sd_addr;
    logic [3:0]  sd_dqm;
    logic [31:0] sd_dq_out;
    logic [31:0] sd_dq_in = '0;

    sdram_cmd_sched dut (.*);

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // ---------------- memory model and timing checker ----------------
    logic [31:0] mem [int];
    logic [31:0] shadow [int];
    logic [3:0]  dqm_at [int];
    bit  mopen [4];
    int  mrow [4], last_act [4], pre_eff [4], last_wr [4];
    bit  ap_cl [4];
    int  last_act_any = -100, last_rd_any = -100, last_wr_any = -100;
    int  n_act = 0, n_pre = 0;
    int  last_act_ba = -1;
    int  pend_due [$], pend_key [$], rd_issue [$];
    logic [31:0] exp_q [$];

    initial for (int i = 0; i < 4; i++) begin
        mopen[i] = 0; mrow[i] = 0; last_act[i] = -100; pre_eff[i] = -100;
        last_wr[i] = -100; ap_cl[i] = 0;
    end

    function automatic int mkey(int b, int r, int c);
        return (b << 19) | (r << 8) | c;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            logic [3:0] code;
            int b, k, cl;
            logic [31:0] w;
            cl = int'(cas_lat);
            dqm_at[cyc] = sd_dqm;
            code = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            b = int'(sd_ba);
            case (code)
                4'b0111: ;
                4'b0011: begin
                    chk(!mopen[b], "R3 activate to closed bank", mopen[b], 0);
                    chk(cyc - pre_eff[b] >= T_RP, ap_cl[b] ? "R9 auto-precharge to activate" : "R5 precharge to activate",
                        cyc - pre_eff[b], T_RP);
                    chk(cyc - last_act[b] >= T_RC, "R6 activate to activate", cyc - last_act[b], T_RC);
                    chk(cyc - last_act_any >= T_RRD, "R7 activate spacing", cyc - last_act_any, T_RRD);
                    mopen[b] = 1; mrow[b] = int'(sd_addr); last_act[b] = cyc; last_act_any = cyc;
                    last_act_ba = b; n_act++; ap_cl[b] = 0;
                end
                4'b0101, 4'b0100: begin
                    chk(mopen[b], "R4 column to open bank", mopen[b], 1);
                    chk(cyc - last_act[b] >= T_RCD, "R4 activate to column", cyc - last_act[b], T_RCD);
                    k = mkey(b, mrow[b], int'(sd_addr[7:0]));
                    if (code == 4'b0100) begin
                        chk(cyc - last_rd_any >= cl + 1, "R13 read to write", cyc - last_rd_any, cl + 1);
                        chk(sd_dq_oe, "R11 bus driven on write", sd_dq_oe, 1);
                        w = mem.exists(k) ? mem[k] : 32'h0;
                        for (int i = 0; i < 4; i++) if (!sd_dqm[i]) w[8*i +: 8] = sd_dq_out[8*i +: 8];
                        mem[k] = w;
                        last_wr[b] = cyc; last_wr_any = cyc;
                    end else begin
                        chk(cyc - last_wr_any >= T_CDL, "R8 write to read", cyc - last_wr_any, T_CDL);
                        pend_due.push_back(cyc + cl); pend_key.push_back(k); rd_issue.push_back(cyc);
                        last_rd_any = cyc;
                    end
                    if (sd_addr[10]) begin
                        mopen[b] = 0; ap_cl[b] = 1;
                        pre_eff[b] = (code == 4'b0100) ? cyc + T_RDL : cyc;
                        if (pre_eff[b] < last_act[b] + T_RAS) pre_eff[b] = last_act[b] + T_RAS;
                    end
                end
                4'b0010: begin
                    chk(!sd_addr[10], "R3 single-bank precharge", sd_addr[10], 0);
                    chk(mopen[b], "R3 precharge of open bank", mopen[b], 1);
                    chk(cyc - last_act[b] >= T_RAS, "R6 activate to precharge", cyc - last_act[b], T_RAS);
                    chk(cyc - last_wr[b] >= T_RDL, "R8 write to precharge", cyc - last_wr[b], T_RDL);
                    mopen[b] = 0; pre_eff[b] = cyc; ap_cl[b] = 0; n_pre++;
                end
                default: chk(1'b0, "R1 command code", code, 4'b0111);
            endcase
            sd_dq_in = 32'h0;
            if (pend_due.size() != 0 && pend_due[0] == cyc) begin
                void'(pend_due.pop_front());
                k = pend_key.pop_front();
                w = mem.exists(k) ? mem[k] : 32'h0;
                if (dqm_at.exists(cyc - 2))
                    for (int i = 0; i < 4; i++) if (dqm_at[cyc - 2][i]) w[8*i +: 8] = 8'h00;
                sd_dq_in = w;
            end
        end
    end

    // ---------------- scoreboard monitor ----------------
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0 || rd_issue.size() == 0) begin
                chk(1'b0, "R10 unexpected read data", rd_data, 0);
            end else begin
                logic [31:0] e;
                int n;
                e = exp_q.pop_front();
                n = rd_issue.pop_front();
                chk(rd_data === e, "R10 R12 read data", rd_data, e);
                chk(cyc == n + int'(cas_lat) + 1, "R10 read latency", cyc - n, int'(cas_lat) + 1);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic send(bit wr, int bank, int row, int col, bit ap, logic [3:0] mask, logic [31:0] data);
        int k;
        logic [31:0] w;
        k = mkey(bank, row, col);
        w = shadow.exists(k) ? shadow[k] : 32'h0;
        if (wr) begin
            for (int i = 0; i < 4; i++) if (!mask[i]) w[8*i +: 8] = data[8*i +: 8];
            shadow[k] = w;
        end else begin
            for (int i = 0; i < 4; i++) if (mask[i]) w[8*i +: 8] = 8'h00;
            exp_q.push_back(w);
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_bank = 2'(bank); req_row = 11'(row);
        req_col = 8'(col); req_autopre = ap; req_mask = mask; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
        repeat (15) @(negedge clk);
    endtask

    always @(posedge clk) if (cyc > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int a0;
        repeat (3) @(negedge clk);
        // R14: reset state
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R14 NOP in reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        chk(rd_valid == 1'b0, "R14 rd_valid low", rd_valid, 0);
        chk(req_ready == 1'b1, "R14 ready high", req_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R14 NOP after reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);

        // CAS latency 3: open row, hit
        send(1, 0, 5, 1, 0, 4'b0000, 32'h11223344);
        send(0, 0, 5, 1, 0, 4'b0000, 0);
        drain();
        a0 = n_act;
        send(0, 0, 5, 1, 0, 4'b0000, 0);
        send(1, 0, 5, 2, 0, 4'b0000, 32'h55667788);
        send(0, 0, 5, 2, 0, 4'b0000, 0);
        drain();
        chk(n_act == a0, "R2 no activate on row hit", n_act, a0);
        chk(n_pre == 0, "R2 no precharge on row hit", n_pre, 0);

        // row miss right after a write (R3, R8)
        send(1, 0, 9, 3, 0, 4'b0000, 32'hCAFEF00D);
        send(0, 0, 9, 3, 0, 4'b0000, 0);
        drain();
        chk(n_pre == 1, "R3 precharge on row miss", n_pre, 1);
        chk(n_act == a0 + 1, "R3 activate on row miss", n_act, a0 + 1);

        // activates to several banks back to back (R7, R1)
        send(1, 1, 1, 0, 0, 4'b0000, 32'hA1A1A1A1);
        send(1, 2, 2, 0, 0, 4'b0000, 32'hB2B2B2B2);
        send(1, 3, 3, 0, 0, 4'b0000, 32'hC3C3C3C3);
        drain();
        chk(last_act_ba == 3, "R1 bank select pins", last_act_ba, 3);

        // masked write (R11), read-to-write turnaround (R13), masked read CL3 (R12)
        send(1, 1, 1, 4, 0, 4'b0000, 32'hAABBCCDD);
        send(1, 1, 1, 4, 0, 4'b0101, 32'h11111111);
        send(0, 1, 1, 4, 0, 4'b0000, 0);
        send(1, 1, 1, 5, 0, 4'b0000, 32'h0BADBEEF);
        send(0, 1, 1, 4, 0, 4'b1001, 0);
        send(0, 1, 1, 5, 0, 4'b0000, 0);
        drain();
        chk(shadow[mkey(1, 1, 4)] == 32'h11BB11DD, "R11 masked write merge", shadow[mkey(1, 1, 4)], 32'h11BB11DD);

        // auto-precharge (R9)
        a0 = n_act;
        send(1, 2, 2, 7, 1, 4'b0000, 32'h77777777);
        send(0, 2, 2, 7, 1, 4'b0000, 0);
        send(0, 2, 2, 7, 0, 4'b0000, 0);
        drain();
        chk(n_act == a0 + 2, "R9 bank reopened after auto-precharge", n_act, a0 + 2);
        chk(n_pre == 1, "R9 no explicit precharge", n_pre, 1);

        // write then row miss on the same bank (R8)
        send(1, 3, 3, 1, 0, 4'b0000, 32'h31313131);
        send(0, 3, 8, 1, 0, 4'b0000, 0);
        drain();

        // CAS latency 2
        cas_lat = 2'd2;
        send(1, 0, 9, 9, 0, 4'b0000, 32'h9ABCDEF0);
        send(0, 0, 9, 9, 0, 4'b0010, 0);
        send(0, 0, 9, 9, 0, 4'b0000, 0);
        send(1, 0, 9, 8, 0, 4'b0000, 32'h01020304);
        drain();

        // CAS latency 1, masked read needs a lead cycle (R12)
        cas_lat = 2'd1;
        send(0, 0, 9, 9, 0, 4'b1100, 0);
        send(0, 0, 9, 3, 0, 4'b0000, 0);
        send(0, 0, 9, 8, 0, 4'b0001, 0);
        send(1, 0, 9, 8, 0, 4'b1000, 32'hFFFFFFFF);
        send(0, 0, 9, 8, 0, 4'b0000, 0);
        send(0, 1, 6, 0, 1, 4'b0000, 0);
        drain();

        chk(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 0);
        chk(pend_due.size() == 0, "R10 no reads left on bus", pend_due.size(), 0);
        finish_run();
    end

endmodule